// File: doc/BRIEF.md
# Parallel SAD Motion Search Engine

This block scores a whole row of candidate positions for block-matching motion estimation in parallel. For every row operation it takes one row of the current block on a 128-bit bus and a window of reference pixels. It works out the sum of absolute differences (SAD) for each of 64 candidate horizontal offsets at once and adds each result to a private accumulator for that candidate. The accumulators keep their values from one operation to the next. A caller can therefore build a 4x4, 8x8 or 16x16 block SAD from several row operations without reloading any partial sums, and can clear the accumulators before a new block.

When the caller flags the final row, a selector compares all candidate totals. One cycle later the block reports the smallest SAD, the index of the candidate that produced it, and a signed motion vector offset derived from that index. A refinement mode limits the comparison to nine candidates. The caller loads the window with already interpolated samples for the centre position and its eight sub-pixel neighbours. In this mode the index maps to a 3x3 grid of offsets around the current best vector.

Top module: `sad_search_engine`

## Requirements
- R1: While `rst` is high and after it is released, `done` is 0 and `best_sad`, `best_idx`, `mv_x` and `mv_y` are all 0.
- R2: Pixel i of `cur_row` is bits [8i+7:8i]. Pixel p of `ref_win` is bits [8p+7:8p]. On a row operation (`row_valid`=1), candidate c adds the sum of |cur pixel i − ref pixel (c+i)| over the active lanes i.
- R3: `blk_size` sets the active lanes: 0 selects lanes 0–3, 1 selects lanes 0–7, and 2 or 3 selects all 16 lanes. Pixels in inactive lanes have no effect on any result.
- R4: A row operation with `clr`=0 adds to the sums left by earlier operations, including sums from an earlier block that was not cleared.
- R5: `clr`=1 with no row operation sets every accumulator to zero. `clr`=1 together with a row operation starts every accumulator from this row alone.
- R6: `done` is high for exactly the cycle after a row operation with `row_last`=1. In that cycle `best_sad` holds the smallest candidate total, including that final row.
- R7: When several candidates share the smallest total, `best_idx` is the lowest of their indices.
- R8: In full search (`sub_mode`=0) all 64 candidates are compared. `mv_x` = `best_idx` − 32 and `mv_y` = 0, both two's complement.
- R9: In refinement (`sub_mode`=1) only candidates 0–8 are compared. `mv_x` = (`best_idx` mod 3) − 1 and `mv_y` = (`best_idx` div 3) − 1.
- R10: Each accumulator is 16 bits. It holds a full 16x16 block with a difference of 255 at every pixel (65280) without wrapping.
- R11: `best_sad`, `best_idx`, `mv_x` and `mv_y` keep their values until the next `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Zero all candidate accumulators |
| row_valid | input | 1 | Row operation this cycle |
| row_last | input | 1 | This row operation ends the block |
| sub_mode | input | 1 | 1 = nine-point refinement, 0 = full search |
| blk_size | input | 2 | Active lane count: 0→4, 1→8, 2/3→16 |
| cur_row | input | 128 | Current-block row, 16 pixels of 8 bits |
| ref_win | input | 632 | Reference window, 79 pixels of 8 bits |
| done | output | 1 | Result valid pulse |
| best_sad | output | 16 | Smallest candidate SAD |
| best_idx | output | 6 | Index of the winning candidate |
| mv_x | output | 7 | Signed horizontal offset of the winner |
| mv_y | output | 7 | Signed vertical offset of the winner |

## Verification
The overflow assertion relies on the caller: a block may add at most 256 active pixels between clears, which means at most 16 rows of at most 16 lanes. Every block in the stimulus obeys this limit, and the continuation case stays inside it by chaining two 4x4 blocks. The refinement-range assertion relies on `sub_mode` being steady during the final row operation, which the driver guarantees. Inputs are driven only on falling edges, so each rising edge sees stable values.

// File: rtl/sad_pkg.sv
package sad_pkg;
    localparam int PIX_W   = 8;
    localparam int LANES   = 16;
    localparam int NCAND   = 64;
    localparam int ACC_W   = 16;
    localparam int SUB_N   = 9;
    localparam int IDX_W   = $clog2(NCAND);
    localparam int MV_W    = IDX_W + 1;
    localparam int WIN_PIX = LANES + NCAND - 1;
    localparam int ROW_W   = PIX_W + $clog2(LANES) + 1;

    typedef logic [ACC_W-1:0] acc_t;

    typedef struct packed {
        acc_t             sad;
        logic [IDX_W-1:0] idx;
    } match_t;

    function automatic int active_lanes(input logic [1:0] sel);
        int n;
        n = 4 << sel;
        if (n > LANES) n = LANES;
        return n;
    endfunction

    function automatic logic signed [MV_W-1:0] vec_dx(input logic [IDX_W-1:0] idx,
                                                      input logic sub);
        int v;
        if (sub) v = (int'(idx) % 3) - 1;
        else     v = int'(idx) - NCAND / 2;
        return MV_W'(v);
    endfunction

    function automatic logic signed [MV_W-1:0] vec_dy(input logic [IDX_W-1:0] idx,
                                                      input logic sub);
        int v;
        if (sub) v = (int'(idx) / 3) - 1;
        else     v = 0;
        return MV_W'(v);
    endfunction
endpackage

// File: rtl/sad_row_unit.sv
module sad_row_unit
    import sad_pkg::*;
(
    input  logic [LANES*PIX_W-1:0] cur,
    input  logic [LANES*PIX_W-1:0] ref_seg,
    input  logic [LANES-1:0]       lane_en,
    output logic [ROW_W-1:0]       row_sad
);
    logic [LANES-1:0][PIX_W-1:0] diff;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [PIX_W-1:0] a, b;
        assign a = cur[l*PIX_W +: PIX_W];
        assign b = ref_seg[l*PIX_W +: PIX_W];
        assign diff[l] = !lane_en[l] ? '0 : (a > b) ? a - b : b - a;
    end

    always_comb begin
        row_sad = '0;
        for (int l = 0; l < LANES; l++)
            row_sad = row_sad + ROW_W'(diff[l]);
    end
endmodule

// File: rtl/sad_acc_bank.sv
module sad_acc_bank
    import sad_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         clr,
    input  logic                         row_valid,
    input  logic [LANES*PIX_W-1:0]       cur,
    input  logic [WIN_PIX*PIX_W-1:0]     ref_win,
    input  logic [LANES-1:0]             lane_en,
    output logic [NCAND-1:0][ACC_W-1:0]  totals
);
    for (genvar c = 0; c < NCAND; c++) begin : g_cand
        logic [ROW_W-1:0] row_sad;
        acc_t             acc;
        acc_t             base;
        logic [ACC_W:0]   sum_ext;

        sad_row_unit u_row (
            .cur     (cur),
            .ref_seg (ref_win[c*PIX_W +: LANES*PIX_W]),
            .lane_en (lane_en),
            .row_sad (row_sad)
        );

        assign base      = clr ? '0 : acc;
        assign sum_ext   = {1'b0, base} + (ACC_W+1)'(row_sad);
        assign totals[c] = sum_ext[ACC_W-1:0];

        always_ff @(posedge clk) begin
            if (rst)            acc <= '0;
            else if (row_valid) acc <= totals[c];
            else if (clr)       acc <= '0;
        end

        // R10: a block of legal size never carries out of the accumulator
        p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
            row_valid |-> !sum_ext[ACC_W]);

        // R5: a clear without a row leaves the accumulator at zero
        p_clear_zero_r5: assert property (@(posedge clk) disable iff (rst)
            (clr && !row_valid) |=> (acc == '0));
    end
endmodule

// File: rtl/sad_min_select.sv
module sad_min_select
    import sad_pkg::*;
(
    input  logic [NCAND-1:0][ACC_W-1:0] totals,
    input  logic                        sub,
    output match_t                      best
);
    always_comb begin
        best.sad = totals[0];
        best.idx = '0;
        for (int i = 1; i < NCAND; i++) begin
            if ((!sub || i < SUB_N) && totals[i] < best.sad) begin
                best.sad = totals[i];
                best.idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/sad_search_engine.sv
module sad_search_engine
    import sad_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          clr,
    input  logic                          row_valid,
    input  logic                          row_last,
    input  logic                          sub_mode,
    input  logic [1:0]                    blk_size,
    input  logic [LANES*PIX_W-1:0]        cur_row,
    input  logic [WIN_PIX*PIX_W-1:0]      ref_win,
    output logic                          done,
    output logic [ACC_W-1:0]              best_sad,
    output logic [IDX_W-1:0]              best_idx,
    output logic signed [MV_W-1:0]        mv_x,
    output logic signed [MV_W-1:0]        mv_y
);
    logic [LANES-1:0]            lane_en;
    logic [NCAND-1:0][ACC_W-1:0] totals;
    match_t                      best;
    logic                        fire;

    always_comb begin
        for (int l = 0; l < LANES; l++)
            lane_en[l] = (l < active_lanes(blk_size));
    end

    sad_acc_bank u_bank (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr),
        .row_valid (row_valid),
        .cur       (cur_row),
        .ref_win   (ref_win),
        .lane_en   (lane_en),
        .totals    (totals)
    );

    sad_min_select u_min (
        .totals (totals),
        .sub    (sub_mode),
        .best   (best)
    );

    assign fire = row_valid && row_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            done     <= 1'b0;
            best_sad <= '0;
            best_idx <= '0;
            mv_x     <= '0;
            mv_y     <= '0;
        end else begin
            done <= fire;
            if (fire) begin
                best_sad <= best.sad;
                best_idx <= best.idx;
                mv_x     <= vec_dx(best.idx, sub_mode);
                mv_y     <= vec_dy(best.idx, sub_mode);
            end
        end
    end

    // R6: result pulse follows the final row by one cycle
    p_done_after_last_r6: assert property (@(posedge clk) disable iff (rst)
        fire |=> done);
    p_done_only_then_r6: assert property (@(posedge clk) disable iff (rst)
        !fire |=> !done);

    // R9: refinement never reports a candidate outside the nine-point set
    p_sub_range_r9: assert property (@(posedge clk) disable iff (rst)
        (fire && sub_mode) |=> (best_idx < IDX_W'(SUB_N)
                                && mv_x >= -1 && mv_x <= 1
                                && mv_y >= -1 && mv_y <= 1));

    // R11: outputs stay put between result pulses
    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !fire |=> ($stable(best_sad) && $stable(best_idx)
                   && $stable(mv_x) && $stable(mv_y)));
endmodule

// File: tb/sad_search_engine_test.sv
module sad_search_engine_test;
    localparam int LN = 16;
    localparam int NC = 64;
    localparam int WP = LN + NC - 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         clr = 1'b0;
    logic         row_valid = 1'b0;
    logic         row_last = 1'b0;
    logic         sub_mode = 1'b0;
    logic [1:0]   blk_size = 2'd2;
    logic [LN*8-1:0] cur_row = '0;
    logic [WP*8-1:0] ref_win = '0;
    logic         done;
    logic [15:0]  best_sad;
    logic [5:0]   best_idx;
    logic [6:0]   mv_x, mv_y;

    always #2.5 clk = ~clk;

    sad_search_engine uut (
        .clk(clk), .rst(rst), .clr(clr), .row_valid(row_valid), .row_last(row_last),
        .sub_mode(sub_mode), .blk_size(blk_size), .cur_row(cur_row), .ref_win(ref_win),
        .done(done), .best_sad(best_sad), .best_idx(best_idx), .mv_x(mv_x), .mv_y(mv_y)
    );

    typedef struct {
        int    sad;
        int    idx;
        int    dx;
        int    dy;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   model_acc[NC];
    int   checks = 0;
    int   errors = 0;
    int   last_sad = 0, last_idx = 0, last_dx = 0, last_dy = 0;
    bit   finished = 0;

    task automatic check(input string tag, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    // Driver: one row operation, model updated and expectation queued
    task automatic do_row(input logic [LN*8-1:0] c, input logic [WP*8-1:0] r,
                          input bit last, input bit doclr, input bit sub,
                          input logic [1:0] bs, input string tag);
        int   lanes, s, a, b, n, bi;
        exp_t e;
        @(negedge clk);
        cur_row = c; ref_win = r; row_valid = 1'b1; row_last = last;
        clr = doclr; sub_mode = sub; blk_size = bs;
        lanes = (bs == 0) ? 4 : (bs == 1) ? 8 : 16;
        for (int k = 0; k < NC; k++) begin
            if (doclr) model_acc[k] = 0;
            s = 0;
            for (int i = 0; i < lanes; i++) begin
                a = int'(c[i*8 +: 8]);
                b = int'(r[(k+i)*8 +: 8]);
                s += (a > b) ? a - b : b - a;
            end
            model_acc[k] += s;
        end
        if (last) begin
            n = sub ? 9 : NC;
            bi = 0;
            for (int k = 1; k < n; k++)
                if (model_acc[k] < model_acc[bi]) bi = k;
            e.sad = model_acc[bi] & 16'hFFFF;
            e.idx = bi;
            e.dx  = sub ? (bi % 3) - 1 : bi - NC / 2;
            e.dy  = sub ? (bi / 3) - 1 : 0;
            e.tag = tag;
            exp_q.push_back(e);
        end
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        row_valid = 1'b0; row_last = 1'b0; clr = 1'b0;
        repeat (n - 1) @(negedge clk);
    endtask

    task automatic clr_only();
        @(negedge clk);
        row_valid = 1'b0; row_last = 1'b0; clr = 1'b1;
        for (int k = 0; k < NC; k++) model_acc[k] = 0;
        @(negedge clk);
        clr = 1'b0;
    endtask

    function automatic logic [LN*8-1:0] rand_cur();
        logic [LN*8-1:0] v;
        for (int i = 0; i < LN; i++) v[i*8 +: 8] = 8'($urandom);
        return v;
    endfunction

    function automatic logic [WP*8-1:0] rand_ref();
        logic [WP*8-1:0] v;
        for (int i = 0; i < WP; i++) v[i*8 +: 8] = 8'($urandom);
        return v;
    endfunction

    task automatic rand_block(input int rows, input logic [1:0] bs, input bit sub,
                              input bit doclr, input string tag);
        for (int r = 0; r < rows; r++)
            do_row(rand_cur(), rand_ref(), r == rows - 1, doclr && r == 0, sub, bs, tag);
    endtask

    // Monitor: pops expectations as results appear
    always @(negedge clk) begin
        if (!rst && done && !finished) begin
            if (exp_q.size() == 0) begin
                check("R6 unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check({e.tag, " sad"}, int'(best_sad), e.sad);
                check({e.tag, " idx"}, int'(best_idx), e.idx);
                check({e.tag, " mv_x"}, int'($signed(mv_x)), e.dx);
                check({e.tag, " mv_y"}, int'($signed(mv_y)), e.dy);
                last_sad = e.sad; last_idx = e.idx; last_dx = e.dx; last_dy = e.dy;
            end
        end
    end

    initial begin
        logic [LN*8-1:0] c;
        logic [WP*8-1:0] r;
        void'($urandom(7));
        for (int k = 0; k < NC; k++) model_acc[k] = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 done", int'(done), 0);
        check("R1 sad", int'(best_sad), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 idx", int'(best_idx), 0);
        check("R1 mv", int'(mv_x) + int'(mv_y), 0);

        rand_block(16, 2'd2, 1'b0, 1'b1, "R2 R8 16x16");
        rand_block(8,  2'd1, 1'b0, 1'b1, "R3 8x8");
        rand_block(4,  2'd0, 1'b0, 1'b1, "R3 4x4");
        rand_block(16, 2'd3, 1'b0, 1'b1, "R3 size3");
        idle(2);
        // R7 all-zero tie: lowest index 0
        do_row('0, '0, 1'b1, 1'b1, 1'b0, 2'd0, "R7 all tie");
        // R7 two zero candidates at 10 and 20
        c = '0;
        for (int i = 0; i < WP; i++) r[i*8 +: 8] = ((i >= 10 && i < 14) || (i >= 20 && i < 24)) ? 8'd0 : 8'd50;
        do_row(c, r, 1'b1, 1'b1, 1'b0, 2'd0, "R7 tie 10/20");
        // R9 refinement
        rand_block(4,  2'd0, 1'b1, 1'b1, "R9 sub 4x4");
        rand_block(16, 2'd2, 1'b1, 1'b1, "R9 sub 16x16");
        // R4 continuation without clear
        rand_block(4, 2'd0, 1'b0, 1'b1, "R4 first");
        rand_block(4, 2'd0, 1'b0, 1'b0, "R4 continued");
        // R5 clear alone, then a block without clear
        idle(2);
        rand_block(2, 2'd1, 1'b0, 1'b1, "R5 dirty");
        idle(1);
        clr_only();
        rand_block(3, 2'd1, 1'b0, 1'b0, "R5 after clr");
        // R10 maximum difference
        c = '1;
        for (int rr = 0; rr < 16; rr++)
            do_row(c, '0, rr == 15, rr == 0, 1'b0, 2'd2, "R10 max");
        idle(4);
        // R11 hold between pulses
        check("R11 hold sad", int'(best_sad), last_sad);
        check("R11 hold idx", int'(best_idx), last_idx);
        check("R11 hold mv_x", int'($signed(mv_x)), last_dx);
        check("R11 hold mv_y", int'($signed(mv_y)), last_dy);
        check("R6 pending results", exp_q.size(), 0);
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule